// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is the chain of scan cells that sits between a device's pins and its core logic. An external test-port controller supplies three strobes: capture, shift and update. A separate instruction decoder supplies a two-bit mode. Each cell has a capture stage that loads in parallel or shifts serially on the rising test-clock edge. Each cell also has a hold stage that takes a copy of the capture stage on the falling edge when update is requested. Serial data enters on `tdi` and leaves on `tdo`, so bits moving through the capture stages never reach the pins or the core.

There are two kinds of cell. Input cells sit on the path from a pin into the core. Output cells sit on the path from the core to a pin, and each output pin has a data cell and an output-enable cell. In the functional and sampling modes, pin and core signals pass straight through. In the external-test mode, the output pins and their enables are driven from the hold stages. In the internal-test mode, the core inputs are also driven from the hold stages. The chain length is `NUM_IN + 2*NUM_OUT` bits.

Top module: `bscan_chain`

## Requirements
- R1: While `trstN` is low, every capture and hold stage is 0, `coreIn` equals `pinIn`, `pinOut` equals `coreOut` and `pinOe` equals `coreOe`, whatever the mode. After release, the hold stages stay 0 until an update.
- R2: Chain position k runs from 0 (the cell fed by `tdi`) to `NUM_IN+2*NUM_OUT-1` (the cell that drives `tdo`). Input cell i is at position i. Output j has its data cell at position `NUM_IN+2j` and its enable cell at `NUM_IN+2j+1`. On a rising edge with `shiftDr` high and `captureDr` low, in any non-functional mode, every position takes the value of the position below it, and position 0 takes `tdi`. `tdo` always shows the top position.
- R3: On a rising edge with `captureDr` high, in any non-functional mode, input cells load `pinIn`, data cells load `coreOut` and enable cells load `coreOe`. Capture takes precedence when `shiftDr` is also high.
- R4: On a falling edge with `updateDr` high, in any non-functional mode, every hold stage copies its capture stage. At no other time does a hold stage change, so the driven pins stay steady while the chain shifts.
- R5: Mode 0 (functional) passes all signals through, and capture, shift and update have no effect.
- R6: Mode 1 (sample/preload) passes all signals through while still capturing, shifting and updating. An update therefore only preloads the hold stages.
- R7: Mode 2 (external test) drives `pinOut[j]` and `pinOe[j]` from the hold stages of output j's data and enable cells, while `coreIn` still follows `pinIn`.
- R8: Mode 3 (internal test) drives `coreIn[i]` from input cell i's hold stage, and drives `pinOut` and `pinOe` from the hold stages, while capture still loads the core outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; capture/shift on rising edge, update on falling edge |
| trstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 functional, 1 sample/preload, 2 external test, 3 internal test |
| captureDr | input | 1 | Parallel capture request |
| shiftDr | input | 1 | Serial shift request |
| updateDr | input | 1 | Hold-stage update request |
| tdi | input | 1 | Serial data into position 0 |
| tdo | output | 1 | Serial data from the top position |
| pinIn | input | NUM_IN | Values arriving at the input pins |
| coreIn | output | NUM_IN | Values presented to the core |
| coreOut | input | NUM_OUT | Core output data |
| coreOe | input | NUM_OUT | Core output enables |
| pinOut | output | NUM_OUT | Data presented to the output pads |
| pinOe | output | NUM_OUT | Enables presented to the output pads |

## Verification
The mode multiplexers are combinational, so `coreIn`, `pinOut` and `pinOe` are compared in the same cycle in which the mode or the pins change. A capture or shift shows up at `tdo` one rising edge after the strobe. An update shows up at the pins after the falling edge that follows the rising edge where `updateDr` went high. Every stimulus is applied 1 ns after a rising edge, and every observation is made 1 ns after the next falling edge. That puts each result at its due point and away from both clock edges. Scan-out results are rebuilt from the order in which the bits leave `tdo`, using the positions given in R2.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC   = 2'd0,
    MODE_SAMPLE = 2'd1,
    MODE_EXTEST = 2'd2,
    MODE_INTEST = 2'd3
  } scanMode_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic capEn;
    logic shiftEn;
    logic updEn;
    logic driveCore;
    logic drivePin;
  } scanCtl_t;

endpackage

// File: rtl/bscan_ctrl.sv
`timescale 1ns/1ps
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic      rstN,
  input  logic [1:0] mode,
  input  logic      captureDr,
  input  logic      shiftDr,
  input  logic      updateDr,
  output scanCtl_t  ctl
);

  scanMode_e modeSel;
  logic      chainActive;

  always_comb begin
    modeSel     = scanMode_e'(mode);
    chainActive = (modeSel != MODE_FUNC);

    ctl.capEn     = chainActive && captureDr;
    ctl.shiftEn   = chainActive && shiftDr && !captureDr;
    ctl.updEn     = chainActive && updateDr;
    // reset forces pass-through regardless of mode
    ctl.driveCore = rstN && (modeSel == MODE_INTEST);
    ctl.drivePin  = rstN && ((modeSel == MODE_EXTEST) || (modeSel == MODE_INTEST));
  end

endmodule

// File: rtl/bscan_cell.sv
`timescale 1ns/1ps
module bscan_cell (
  input  logic tck,
  input  logic rstN,
  input  logic capEn,
  input  logic shiftEn,
  input  logic updEn,
  input  logic drive,
  input  logic parIn,
  input  logic serIn,
  input  logic funcIn,
  output logic capQ,
  output logic holdQ,
  output logic cellOut
);

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)        capQ <= 1'b0;
    else if (capEn)   capQ <= parIn;
    else if (shiftEn) capQ <= serIn;
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN)      holdQ <= 1'b0;
    else if (updEn) holdQ <= capQ;
  end

  assign cellOut = drive ? holdQ : funcIn;

  // R3
  cap_load_chk: assert property (@(posedge tck) disable iff (!rstN)
    capEn |=> (capQ == $past(parIn)));

  // R2
  shift_move_chk: assert property (@(posedge tck) disable iff (!rstN)
    shiftEn |=> (capQ == $past(serIn)));

  // R4
  hold_keep_chk: assert property (@(negedge tck) disable iff (!rstN)
    !$past(updEn) |-> $stable(holdQ));

  // R4
  hold_load_chk: assert property (@(negedge tck) disable iff (!rstN)
    updEn |=> (holdQ == $past(capQ)));

endmodule

// File: rtl/bscan_datapath.sv
`timescale 1ns/1ps
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 3
) (
  input  logic               tck,
  input  logic               rstN,
  input  scanCtl_t           ctl,
  input  logic               tdi,
  output logic               tdo,
  input  logic [NUM_IN-1:0]  pinIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_OUT-1:0] pinOut,
  output logic [NUM_OUT-1:0] pinOe
);

  localparam int CHAIN_LEN = NUM_IN + 2 * NUM_OUT;

  logic [CHAIN_LEN-1:0] parVec;
  logic [CHAIN_LEN-1:0] driveVec;
  logic [CHAIN_LEN-1:0] outVec;
  logic [CHAIN_LEN-1:0] holdVec;
  logic [CHAIN_LEN:0]   serLink;

  assign serLink[0] = tdi;
  assign tdo        = serLink[CHAIN_LEN];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_inMap
    assign parVec[i]   = pinIn[i];
    assign driveVec[i] = ctl.driveCore;
    assign coreIn[i]   = outVec[i];
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_outMap
    localparam int DATA_POS = NUM_IN + 2 * j;
    assign parVec[DATA_POS]     = coreOut[j];
    assign parVec[DATA_POS+1]   = coreOe[j];
    assign driveVec[DATA_POS]   = ctl.drivePin;
    assign driveVec[DATA_POS+1] = ctl.drivePin;
    assign pinOut[j]            = outVec[DATA_POS];
    assign pinOe[j]             = outVec[DATA_POS+1];
  end

  for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_cell
    bscan_cell u_cell (
      .tck     (tck),
      .rstN    (rstN),
      .capEn   (ctl.capEn),
      .shiftEn (ctl.shiftEn),
      .updEn   (ctl.updEn),
      .drive   (driveVec[k]),
      .parIn   (parVec[k]),
      .serIn   (serLink[k]),
      .funcIn  (parVec[k]),
      .capQ    (serLink[k+1]),
      .holdQ   (holdVec[k]),
      .cellOut (outVec[k])
    );
  end

  // R1
  hold_clear_chk: assert property (@(posedge tck)
    !rstN |-> (holdVec == '0));

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 3
) (
  input  logic               tck,
  input  logic               trstN,
  input  logic [1:0]         mode,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               tdi,
  output logic               tdo,
  input  logic [NUM_IN-1:0]  pinIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_OUT-1:0] pinOut,
  output logic [NUM_OUT-1:0] pinOe
);

  scanCtl_t ctl;

  bscan_ctrl u_ctrl (
    .rstN      (trstN),
    .mode      (mode),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .ctl       (ctl)
  );

  bscan_datapath #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT)
  ) u_dp (
    .tck     (tck),
    .rstN    (trstN),
    .ctl     (ctl),
    .tdi     (tdi),
    .tdo     (tdo),
    .pinIn   (pinIn),
    .coreIn  (coreIn),
    .coreOut (coreOut),
    .coreOe  (coreOe),
    .pinOut  (pinOut),
    .pinOe   (pinOe)
  );

  // R6
  sample_pass_chk: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'd1) |-> (coreIn == pinIn && pinOut == coreOut && pinOe == coreOe));

  // R5
  func_pass_chk: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'd0) |-> (coreIn == pinIn && pinOut == coreOut && pinOe == coreOe));

  // R7
  extest_core_chk: assert property (@(posedge tck) disable iff (!trstN)
    (mode == 2'd2) |-> (coreIn == pinIn));

endmodule

// File: tb/bscan_chain_tb.sv
`timescale 1ns/1ps
module bscan_chain_tb;

  localparam int NI = 4;
  localparam int NO = 3;
  localparam int L  = NI + 2 * NO;
  localparam int NROWS = 6;

  typedef struct packed {
    logic [1:0]    mode;
    logic [NI-1:0] pin;
    logic [NO-1:0] cout;
    logic [NO-1:0] coe;
    logic [L-1:0]  pre;
  } row_t;

  localparam row_t ROWS [NROWS] = '{
    '{2'd1, 4'hA, 3'b101, 3'b011, 10'h2D5},
    '{2'd2, 4'h3, 3'b110, 3'b100, 10'h1B6},
    '{2'd3, 4'hC, 3'b011, 3'b111, 10'h3A9},
    '{2'd0, 4'h5, 3'b001, 3'b010, 10'h0F3},
    '{2'd2, 4'hF, 3'b000, 3'b001, 10'h3FF},
    '{2'd3, 4'h0, 3'b111, 3'b000, 10'h155}
  };

  logic          tck = 1'b0;
  logic          trstN = 1'b0;
  logic [1:0]    mode = 2'd2;
  logic          captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic          tdo;
  logic [NI-1:0] pinIn = '0, coreIn;
  logic [NO-1:0] coreOut = '0, coreOe = '0, pinOut, pinOe;

  int cmpCnt = 0;
  int badCnt = 0;

  always #2 tck = ~tck;

  bscan_chain #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
    .tck(tck), .trstN(trstN), .mode(mode), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .pinIn(pinIn), .coreIn(coreIn), .coreOut(coreOut), .coreOe(coreOe),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    cmpCnt++;
    if (act !== exp) begin
      badCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // chain image of a parallel capture, positions per R2
  function automatic logic [L-1:0] capVec(logic [NI-1:0] p, logic [NO-1:0] d, logic [NO-1:0] e);
    logic [L-1:0] v;
    for (int i = 0; i < NI; i++) v[i] = p[i];
    for (int j = 0; j < NO; j++) begin
      v[NI+2*j]   = d[j];
      v[NI+2*j+1] = e[j];
    end
    return v;
  endfunction

  // expected {coreIn, pinOut, pinOe} per R5..R8
  function automatic logic [L-1:0] expOut(logic [1:0] m, logic [L-1:0] h,
      logic [NI-1:0] p, logic [NO-1:0] d, logic [NO-1:0] e);
    logic [NI-1:0] ci;
    logic [NO-1:0] po, pe;
    ci = (m == 2'd3) ? h[NI-1:0] : p;
    for (int j = 0; j < NO; j++) begin
      po[j] = (m >= 2'd2) ? h[NI+2*j]   : d[j];
      pe[j] = (m >= 2'd2) ? h[NI+2*j+1] : e[j];
    end
    return {ci, po, pe};
  endfunction

  function automatic logic [2*NO-1:0] pinsOf(logic [L-1:0] h);
    logic [NO-1:0] po, pe;
    for (int j = 0; j < NO; j++) begin
      po[j] = h[NI+2*j];
      pe[j] = h[NI+2*j+1];
    end
    return {po, pe};
  endfunction

  task automatic doScan(input logic [L-1:0] din, output logic [L-1:0] dout,
                        input bit watch, input logic [2*NO-1:0] pinsExp);
    for (int k = L - 1; k >= 0; k--) begin
      @(posedge tck); #1 shiftDr = 1'b1; tdi = din[k];
      #2 dout[k] = tdo;
      if (watch) check("R4 pins steady while shifting", {26'd0, pinOut, pinOe}, {26'd0, pinsExp});
    end
    @(posedge tck); #1 shiftDr = 1'b0; tdi = 1'b0;
  endtask

  task automatic pulseUpdate();
    @(posedge tck); #1 updateDr = 1'b1;
    @(posedge tck); #1 updateDr = 1'b0;
  endtask

  task automatic pulseCapture(input bit withShift);
    @(posedge tck); #1 captureDr = 1'b1; shiftDr = withShift;
    @(posedge tck); #1 captureDr = 1'b0; shiftDr = 1'b0;
  endtask

  task automatic settle();
    @(posedge tck); #3;
  endtask

  string modeTag [4] = '{"R5 functional", "R6 sample", "R7 extest", "R8 intest"};

  initial begin
    logic [L-1:0] got;
    logic [L-1:0] expCap;

    // R1: reset forces pass-through even with external-test mode selected
    pinIn = 4'h9; coreOut = 3'b110; coreOe = 3'b101;
    repeat (3) @(posedge tck);
    #3 check("R1 pass-through in reset", {22'd0, coreIn, pinOut, pinOe}, {22'd0, 4'h9, 3'b110, 3'b101});
    @(posedge tck); #1 trstN = 1'b1;
    settle();
    check("R1 hold cleared after reset", {26'd0, pinOut, pinOe}, 32'd0);
    mode = 2'd1;
    doScan('1, got, 1'b0, '0);
    check("R1 capture stages cleared", {22'd0, got}, 32'd0);

    // table walk: preload, apply mode, compare outputs, capture, scan out
    for (int r = 0; r < NROWS; r++) begin
      mode = 2'd1;
      pinIn = ROWS[r].pin; coreOut = ROWS[r].cout; coreOe = ROWS[r].coe;
      doScan(ROWS[r].pre, got, 1'b0, '0);
      pulseUpdate();
      @(posedge tck); #1 mode = ROWS[r].mode;
      #2 check(modeTag[ROWS[r].mode], {22'd0, coreIn, pinOut, pinOe},
               {22'd0, expOut(ROWS[r].mode, ROWS[r].pre, ROWS[r].pin, ROWS[r].cout, ROWS[r].coe)});
      pulseCapture(1'b0);
      @(posedge tck); #1 mode = 2'd1;
      doScan('0, got, 1'b0, '0);
      expCap = (ROWS[r].mode == 2'd0) ? ROWS[r].pre : capVec(ROWS[r].pin, ROWS[r].cout, ROWS[r].coe);
      check((ROWS[r].mode == 2'd0) ? "R5 capture ignored" : "R3 captured image", {22'd0, got}, {22'd0, expCap});
    end

    // R3: capture wins over shift
    mode = 2'd1; pinIn = 4'h6; coreOut = 3'b010; coreOe = 3'b110;
    doScan(10'h2AA, got, 1'b0, '0);
    pulseCapture(1'b1);
    doScan('0, got, 1'b0, '0);
    check("R3 capture over shift", {22'd0, got}, {22'd0, capVec(4'h6, 3'b010, 3'b110)});

    // R2: chain order round trip
    doScan(10'h301, got, 1'b0, '0);
    doScan(10'h0CE, got, 1'b0, '0);
    check("R2 shift order", {22'd0, got}, {22'd0, 10'h301});

    // R5: update and shift ignored in functional mode
    doScan(10'h2B4, got, 1'b0, '0);
    pulseUpdate();
    doScan(10'h14B, got, 1'b0, '0);
    @(posedge tck); #1 mode = 2'd0;
    pulseUpdate();
    doScan(10'h3FF, got, 1'b0, '0);
    @(posedge tck); #1 mode = 2'd2;
    #2 check("R5 update ignored", {26'd0, pinOut, pinOe}, {26'd0, pinsOf(10'h2B4)});
    @(posedge tck); #1 mode = 2'd1;
    doScan('0, got, 1'b0, '0);
    check("R5 shift ignored", {22'd0, got}, {22'd0, 10'h14B});

    // R4: pins hold while shifting in external test, then change on update
    @(posedge tck); #1 mode = 2'd2;
    doScan(10'h1E7, got, 1'b1, pinsOf(10'h2B4));
    pulseUpdate();
    #2 check("R4 update applies", {26'd0, pinOut, pinOe}, {26'd0, pinsOf(10'h1E7)});

    // R1: mid-run reset
    pinIn = 4'h3; coreOut = 3'b100; coreOe = 3'b001;
    @(posedge tck); #1 trstN = 1'b0;
    repeat (2) @(posedge tck);
    #3 check("R1 mid-run reset pass-through", {22'd0, coreIn, pinOut, pinOe}, {22'd0, 4'h3, 3'b100, 3'b001});
    @(posedge tck); #1 trstN = 1'b1;
    settle();
    check("R1 hold zero after reset", {26'd0, pinOut, pinOe}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, badCnt);
    $finish;
  end

  initial begin
    #400000;
    cmpCnt++;
    badCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, badCnt);
    $finish;
  end

endmodule